// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt conditions of a FIFO-capable serial controller and presents them to a host through a small byte-wide register bus. The conditions are a receive-data condition, a receive timeout, an empty transmit holding register, a line status error and a modem status change. The block keeps the enable mask, the FIFO control settings and the modem control byte. From these it builds an identification byte that names the most urgent enabled cause. It also drives one interrupt request line, which a master gate bit in the modem control byte can hold inactive.

The receive-data condition compares the receive FIFO fill level against a trigger level that the host programs. A separate timeout counter watches for bytes that sit below the trigger. It counts character-time strobes while the FIFO holds data and nothing moves in or out. The host reads the identification byte from its interrupt handler to find the cause. It then services that cause through the rest of the controller, which is outside this block. Writes to the FIFO control address also produce one-cycle flush strobes for the FIFO storage.

Register addresses on `bus_addr`: 0 is the data port. A write there counts as a transmit holding register write, and a read there counts as a receive data read. The data port itself reads as zero here. Address 1 is the enable mask, address 2 is identification on read and FIFO control on write, and address 4 is modem control. Every other address reads as zero. Reads are combinational; their side effects take place at the clock edge of the read cycle.

Top module: `uart_irq_id`

## Requirements
- R1: Address 1 stores write data bits 3:0 as the enable mask: bit 0 receive data/timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status. It reads back {4'b0000, mask}, and is 8'h00 after reset.
- R2: The identification byte is {mode, 2'b00, timeout, cause[1:0], nopend}. Mode is 2'b11 when the FIFOs are enabled and 2'b00 otherwise. With nothing pending, nopend is 1 and bits 3:1 are 000, so reset reads 8'h01.
- R3: Enabled causes rank from highest to lowest as follows, with codes: line status error (11), receive data or timeout (10), transmit empty (01), modem status change (00). Only the highest one is reported, and nopend is then 0.
- R4: With FIFOs enabled, the receive cause is active when rx_level is at least the trigger level chosen by FIFO control bits 7:6 (00=1, 01=4, 10=8, 11=14 bytes). With FIFOs disabled the trigger is 1 byte.
- R5: With FIFOs enabled, the timeout flag is set once four char_tick strobes have occurred while rx_level is nonzero with no rx_push and no read of address 0. A push, a data read, an RX flush or an empty FIFO clears it. The flag is reported as byte bit 3 together with code 10, and at no other time.
- R6: A thr_empty_set strobe latches a transmit-empty pending flag. A write to address 0 clears it. A read of the identification byte also clears it, but only while transmit empty is the reported cause.
- R7: Address 4 stores and reads back bits 4:0. irq is 1 exactly when a cause is reported and modem control bit 3 is 1.
- R8: A write to address 2 sets the FIFO enable from bit 0 and the trigger select from bits 7:6. It pulses rx_flush (bit 1) and tx_flush (bit 2) high for the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | A new character entered the receive FIFO |
| char_tick | input | 1 | One strobe per character time |
| thr_empty_set | input | 1 | Transmit holding register became empty |
| lsr_err | input | 1 | Line status error present (level) |
| msr_chg | input | 1 | Modem status change present (level) |
| irq | output | 1 | Gated interrupt request |
| fifo_en | output | 1 | FIFO mode enabled |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| tx_flush | output | 1 | One-cycle transmit FIFO flush |

## Verification
The bench walks rx_level across the boundary of each of the four trigger levels. An off-by-one compare would report the receive cause one byte early or late. It checks character mode too, where a stale trigger select would wrongly delay the cause. It stacks all four causes and removes them one by one. A wrong priority order, or a wrong code, shows up as a wrong identification byte at some step. It tells an identification read that clears a reported transmit-empty flag apart from one that clears a flag hidden under a higher cause. It counts timeout strobes to three and then to four, to catch a timeout that fires at the wrong count or survives a data read. It also checks that the master gate holds irq low while a cause is pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_MASK = 3'd1;
    localparam logic [2:0] ADDR_IDFC = 3'd2;
    localparam logic [2:0] ADDR_MCTL = 3'd4;

    typedef enum logic [1:0] {
        CAUSE_MODEM = 2'b00,
        CAUSE_TX    = 2'b01,
        CAUSE_RX    = 2'b10,
        CAUSE_LINE  = 2'b11
    } cause_e;

    typedef struct packed {
        logic line;
        logic rx;
        logic tmo;
        logic tx;
        logic modem;
    } src_t;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] zero;
        logic       tmo;
        cause_e     cause;
        logic       nopend;
    } idbyte_t;

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [3:0] ier,
    output logic       fifo_en,
    output logic [1:0] trig_sel,
    output logic [4:0] mcr,
    output logic       rx_flush,
    output logic       tx_flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ier      <= 4'h0;
            fifo_en  <= 1'b0;
            trig_sel <= 2'b00;
            mcr      <= 5'h00;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    ADDR_MASK: ier <= bus_wdata[3:0];
                    ADDR_IDFC: begin
                        fifo_en  <= bus_wdata[0];
                        rx_flush <= bus_wdata[1];
                        tx_flush <= bus_wdata[2];
                        trig_sel <= bus_wdata[7:6];
                    end
                    ADDR_MCTL: mcr <= bus_wdata[4:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
    parameter int LVL_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             fifo_en,
    input  logic             rx_push,
    input  logic             host_rx_rd,
    input  logic             rx_flush,
    input  logic             char_tick,
    output logic             to_flag
);

    localparam int CNT_W = $clog2(TO_CHARS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TO_CHARS);

    logic [CNT_W-1:0] cnt_q;
    logic             restart;

    assign restart = (rx_level == '0) || rx_push || host_rx_rd || rx_flush || !fifo_en;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (char_tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign to_flag = (cnt_q == CNT_MAX);

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ier,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             to_flag,
    input  logic             lsr_err,
    input  logic             msr_chg,
    input  logic             thr_empty_set,
    input  logic             thr_wr,
    input  logic             id_rd,
    output logic [7:0]       iir,
    output logic             pending
);

    logic             tx_pend_q;
    logic [LVL_W-1:0] thresh;
    src_t             src;
    idbyte_t          idb;

    assign thresh = fifo_en ? LVL_W'(trig_bytes(trig_sel)) : LVL_W'(1);

    always_comb begin
        src.line  = ier[2] & lsr_err;
        src.rx    = ier[0] & (rx_level >= thresh) & (rx_level != '0);
        src.tmo   = ier[0] & to_flag;
        src.tx    = ier[1] & tx_pend_q;
        src.modem = ier[3] & msr_chg;
    end

    always_comb begin
        idb.mode   = {2{fifo_en}};
        idb.zero   = 2'b00;
        idb.tmo    = 1'b0;
        idb.cause  = CAUSE_MODEM;
        idb.nopend = 1'b0;
        if (src.line) begin
            idb.cause = CAUSE_LINE;
        end else if (src.rx || src.tmo) begin
            idb.cause = CAUSE_RX;
            idb.tmo   = src.tmo;
        end else if (src.tx) begin
            idb.cause = CAUSE_TX;
        end else if (!src.modem) begin
            idb.nopend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_pend_q <= 1'b0;
        end else begin
            tx_pend_q <= (tx_pend_q
                          & ~thr_wr
                          & ~(id_rd && !idb.nopend && idb.cause == CAUSE_TX))
                         | thr_empty_set;
        end
    end

    assign iir     = idb;
    assign pending = ~idb.nopend;

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uirq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             char_tick,
    input  logic             thr_empty_set,
    input  logic             lsr_err,
    input  logic             msr_chg,
    output logic             irq,
    output logic             fifo_en,
    output logic             rx_flush,
    output logic             tx_flush
);

    logic [3:0] ier;
    logic [1:0] trig_sel;
    logic [4:0] mcr;
    logic       to_flag;
    logic [7:0] iir;
    logic       pending;
    logic       out2;
    logic       host_rx_rd;
    logic       thr_wr;
    logic       id_rd;

    assign host_rx_rd = bus_rd && bus_addr == ADDR_DATA;
    assign thr_wr     = bus_wr && bus_addr == ADDR_DATA;
    assign id_rd      = bus_rd && bus_addr == ADDR_IDFC;
    assign out2       = mcr[3];

    uirq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .ier       (ier),
        .fifo_en   (fifo_en),
        .trig_sel  (trig_sel),
        .mcr       (mcr),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush)
    );

    uirq_rx_timeout #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) u_tmo (
        .clk        (clk),
        .rst        (rst),
        .rx_level   (rx_level),
        .fifo_en    (fifo_en),
        .rx_push    (rx_push),
        .host_rx_rd (host_rx_rd),
        .rx_flush   (rx_flush),
        .char_tick  (char_tick),
        .to_flag    (to_flag)
    );

    uirq_prio #(.LVL_W(LVL_W)) u_prio (
        .clk           (clk),
        .rst           (rst),
        .ier           (ier),
        .fifo_en       (fifo_en),
        .trig_sel      (trig_sel),
        .rx_level      (rx_level),
        .to_flag       (to_flag),
        .lsr_err       (lsr_err),
        .msr_chg       (msr_chg),
        .thr_empty_set (thr_empty_set),
        .thr_wr        (thr_wr),
        .id_rd         (id_rd),
        .iir           (iir),
        .pending       (pending)
    );

    always_comb begin
        case (bus_addr)
            ADDR_MASK: bus_rdata = {4'h0, ier};
            ADDR_IDFC: bus_rdata = iir;
            ADDR_MCTL: bus_rdata = {3'b000, mcr};
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign irq = pending & out2;

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] iir,
    input logic [3:0] ier,
    input logic       fifo_en,
    input logic       out2,
    input logic       lsr_err,
    input logic       irq,
    input logic       rx_flush
);

    AST_MASK_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd1) |-> bus_rdata[7:4] == 4'h0); // R1

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        iir[0] |-> iir[3:1] == 3'b000); // R2

    AST_MODE_BITS: assert property (@(posedge clk) disable iff (rst)
        iir[7:6] == {2{fifo_en}} && iir[5:4] == 2'b00); // R2

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (lsr_err && ier[2]) |-> iir[3:0] == 4'b0110); // R3

    AST_TMO_ONLY_RX: assert property (@(posedge clk) disable iff (rst)
        iir[3] |-> iir[2:1] == 2'b10); // R5

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (out2 && !iir[0])); // R7

    AST_FLUSH_SRC: assert property (@(posedge clk) disable iff (rst)
        rx_flush |-> $past(bus_wr && bus_addr == 3'd2 && bus_wdata[1])); // R8

endmodule

bind uart_irq_id uirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .iir       (iir),
    .ier       (ier),
    .fifo_en   (fifo_en),
    .out2      (out2),
    .lsr_err   (lsr_err),
    .irq       (irq),
    .rx_flush  (rx_flush)
);

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [LVL_W-1:0] rx_level = '0;
    logic             rx_push = 1'b0;
    logic             char_tick = 1'b0;
    logic             thr_empty_set = 1'b0;
    logic             lsr_err = 1'b0;
    logic             msr_chg = 1'b0;
    logic             irq;
    logic             fifo_en;
    logic             rx_flush;
    logic             tx_flush;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_id u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .rx_level      (rx_level),
        .rx_push       (rx_push),
        .char_tick     (char_tick),
        .thr_empty_set (thr_empty_set),
        .lsr_err       (lsr_err),
        .msr_chg       (msr_chg),
        .irq           (irq),
        .fifo_en       (fifo_en),
        .rx_flush      (rx_flush),
        .tx_flush      (tx_flush)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse_thr();
        thr_empty_set = 1'b1;
        @(negedge clk);
        thr_empty_set = 1'b0;
    endtask

    task automatic pulse_tick();
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk(3'd1, 8'h00, "R1 reset mask");
        rd_chk(3'd2, 8'h01, "R2 reset id");
        rd_chk(3'd4, 8'h00, "R7 reset mctl");
        check("R7 reset irq", irq, 0);
    endtask

    task automatic t_regs();
        wr(3'd1, 8'hFF);
        rd_chk(3'd1, 8'h0F, "R1 mask readback");
        wr(3'd4, 8'hFF);
        rd_chk(3'd4, 8'h1F, "R7 mctl readback");
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_fcr();
        wr(3'd2, 8'h01);
        rd_chk(3'd2, 8'hC1, "R2 fifo mode id");
        check("R8 fifo_en", fifo_en, 1);
        bus_addr = 3'd2; bus_wdata = 8'h03; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 rx_flush pulse", rx_flush, 1);
        check("R8 tx_flush quiet", tx_flush, 0);
        @(negedge clk);
        check("R8 rx_flush one cycle", rx_flush, 0);
        wr(3'd2, 8'h05);
        check("R8 tx_flush pulse", tx_flush, 1);
        wr(3'd2, 8'h00);
        rd_chk(3'd2, 8'h01, "R2 char mode id");
    endtask

    task automatic t_trigger();
        int lv [4] = '{1, 4, 8, 14};
        wr(3'd1, 8'h01);
        for (int s = 0; s < 4; s++) begin
            wr(3'd2, 8'((s << 6) | 1));
            rx_level = LVL_W'(lv[s] - 1);
            #1 check($sformatf("R4 below trigger sel %0d", s), bus_rdata_id(), 8'hC1);
            rx_level = LVL_W'(lv[s]);
            #1 check($sformatf("R4 at trigger sel %0d", s), bus_rdata_id(), 8'hC4);
            rx_level = '0;
            @(negedge clk);
        end
        wr(3'd2, 8'hC0);
        rx_level = LVL_W'(1);
        #1 check("R4 char mode one byte", bus_rdata_id(), 8'h04);
        rx_level = '0;
        wr(3'd1, 8'h00);
    endtask

    function automatic logic [7:0] bus_rdata_id();
        return u_dut.bus_rdata;
    endfunction

    task automatic t_priority();
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h0F);
        pulse_thr();
        lsr_err = 1'b1; msr_chg = 1'b1; rx_level = LVL_W'(3);
        rd_chk(3'd2, 8'hC6, "R3 line highest");
        lsr_err = 1'b0;
        rd_chk(3'd2, 8'hC4, "R3 rx above tx");
        rd_chk(3'd2, 8'hC4, "R6 hidden tx not cleared");
        rx_level = '0;
        @(negedge clk);
        rd_chk(3'd2, 8'hC2, "R3 tx above modem");
        rd_chk(3'd2, 8'hC0, "R6 id read clears tx");
        msr_chg = 1'b0;
        rd_chk(3'd2, 8'hC1, "R3 nothing left");
        pulse_thr();
        wr(3'd0, 8'h55);
        rd_chk(3'd2, 8'hC1, "R6 data write clears tx");
        wr(3'd1, 8'h00);
    endtask

    task automatic t_timeout();
        wr(3'd2, 8'h41);
        wr(3'd1, 8'h01);
        rx_level = LVL_W'(2);
        for (int i = 0; i < 3; i++) pulse_tick();
        rd_chk(3'd2, 8'hC1, "R5 three ticks no timeout");
        pulse_tick();
        rd_chk(3'd2, 8'hCC, "R5 timeout after four ticks");
        rd_chk(3'd0, 8'h00, "R5 data read");
        rd_chk(3'd2, 8'hC1, "R5 data read clears timeout");
        for (int i = 0; i < 3; i++) pulse_tick();
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        pulse_tick();
        rd_chk(3'd2, 8'hC1, "R5 push restarts count");
        rx_level = '0;
        wr(3'd1, 8'h00);
    endtask

    task automatic t_gate();
        wr(3'd1, 8'h04);
        lsr_err = 1'b1;
        #1 check("R7 gate closed", irq, 0);
        wr(3'd4, 8'h08);
        #1 check("R7 gate open", irq, 1);
        lsr_err = 1'b0;
        #1 check("R7 no cause no irq", irq, 0);
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_fcr();
        t_trigger();
        t_priority();
        t_timeout();
        t_gate();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule